// File: doc/BRIEF.md
# Link Command Register/Port Decoder

This block sits behind a serial link receiver and turns the incoming stream of bytes and end-of-packet markers into accesses to a small internal register file and to byte ports that behave like FIFOs. Every packet starts with one command byte. Bit 7 of that byte chooses read or write, and bits 6..0 hold a 7-bit address. Register addresses run from 0x00 to 0x5F. Port addresses run from 0x60 to 0x7F.

A register write carries exactly one value byte. A register read produces a reply packet on the transmit stream. A port write pushes every data byte of the packet into the port. A port read drains the port into a reply packet, up to an optional length limit. While a reply is being sent, the receive side is held off, so commands are handled strictly one at a time.

For test, the block contains a register file of `NREGS` bytes and one loopback FIFO port at 0x60. The last register (index `NREGS-1`) holds the port-read length limit.

Top module: `lnk_cmd_decoder`

## Requirements
- R1: A packet's first byte is the command: bit 7 = 1 is a read and bit 7 = 0 is a write, with bits 6..0 as the address. Addresses 0x00–0x5F are registers and 0x60–0x7F are ports. An end-of-packet marker arriving where a command is expected (an empty packet) is ignored.
- R2: A register write is a packet of command, exactly one value byte, then end-of-packet. The value is stored when the end-of-packet is accepted, and a later read returns it.
- R3: A register write packet with zero value bytes, or with two or more, changes no register and sets `err_flag`. `err_flag` stays at 1 until reset and is 0 after reset.
- R4: A register read packet produces the reply byte {1'b0, address}, then the register value, then an end-of-packet marker (`tx_eop`=1, `tx_data`=0x00). Data bytes between a read command and its end-of-packet are ignored.
- R5: Register addresses from `NREGS` to 0x5F are unmapped. They read as 0x00, and writes to them have no effect and do not set `err_flag`.
- R6: A port write to 0x60 pushes each data byte into the loopback FIFO in arrival order. Bytes that arrive while the FIFO holds `FIFO_DEPTH` bytes are dropped. Writes to the other port addresses are discarded.
- R7: A port read of 0x60 replies {1'b0, address}, then FIFO bytes in order until the FIFO is empty or the count reaches the value of register `NREGS-1` (0 means no limit), then end-of-packet. Bytes that are not sent stay in the FIFO. A read of any other port replies with the address byte and end-of-packet only.
- R8: `rx_ready` is 0 from the acceptance of a read's end-of-packet until the reply's end-of-packet is accepted. While `tx_valid`=1 and `tx_ready`=0, `tx_valid`, `tx_data` and `tx_eop` hold their values.
- R9: After reset all registers are 0x00, the FIFO is empty, `tx_valid`=0, `rx_ready`=1 and `err_flag`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Receive item present |
| rx_eop | input | 1 | Receive item is an end-of-packet marker (data ignored) |
| rx_data | input | 8 | Receive data byte |
| rx_ready | output | 1 | Block accepts the receive item this cycle |
| tx_valid | output | 1 | Reply item present |
| tx_eop | output | 1 | Reply item is an end-of-packet marker |
| tx_data | output | 8 | Reply data byte |
| tx_ready | input | 1 | Downstream accepts the reply item |
| err_flag | output | 1 | Sticky malformed register-write flag |

## Verification
The bench builds the block with `NREGS`=8 and `FIFO_DEPTH`=4. With these values the length-limit register sits at 0x07, and the unmapped range 0x08–0x5F can be probed at both of its ends. The shallow FIFO also makes overflow reachable after only four pushes. A throttled `tx_ready` pattern exercises the hold rule on register and port replies.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam logic [6:0] LCD_PORT_BASE = 7'h60;
    localparam logic [6:0] LCD_LOOP_PORT = 7'h60;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_WDATA,
        ST_PWRITE,
        ST_RSKIP,
        ST_RADDR,
        ST_RREG,
        ST_RPORT,
        ST_REOP
    } lcd_state_e;

    typedef struct packed {
        lcd_state_e st;
        logic [6:0] addr;
        logic [7:0] wval;
        logic [1:0] nbytes;
        logic [7:0] sent;
        logic       err;
    } lcd_parse_t;

endpackage

// File: rtl/lcd_regfile.sv
module lcd_regfile #(
    parameter int NREGS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [6:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] limit
);
    logic [7:0] regs_q [NREGS];
    logic [7:0] regs_d [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        assign regs_d[i] = (we && addr == 7'(i)) ? wdata : regs_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= 8'h00;
        end else begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= regs_d[i];
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NREGS; i++) begin
            if (addr == 7'(i)) rdata = regs_q[i];
        end
    end

    assign limit = regs_q[NREGS-1];

endmodule

// File: rtl/lcd_fifo.sv
module lcd_fifo #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       pop,
    output logic [7:0] head,
    output logic       full,
    output logic       empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } ptr_t;

    ptr_t       q, d;
    logic [7:0] mem_q [DEPTH];

    assign empty = (q.wp == q.rp);
    assign full  = (q.wp[AW] != q.rp[AW]) && (q.wp[AW-1:0] == q.rp[AW-1:0]);
    assign head  = mem_q[q.rp[AW-1:0]];

    always_comb begin
        d = q;
        if (push && !full) d.wp = q.wp + 1'b1;
        if (pop && !empty) d.rp = q.rp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem_q[q.wp[AW-1:0]] <= push_data;
    end

endmodule

// File: rtl/lcd_parser.sv
module lcd_parser
    import lcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic       rx_eop,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       tx_valid,
    output logic       tx_eop,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    output logic       reg_we,
    output logic [6:0] reg_addr,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata,
    input  logic [7:0] limit,
    output logic       push,
    input  logic       full,
    output logic       pop,
    input  logic [7:0] head,
    input  logic       empty,
    output logic       err_flag
);
    lcd_parse_t q, d;
    logic       rx_fire;
    logic       port_more;

    assign reg_addr  = q.addr;
    assign reg_wdata = q.wval;
    assign err_flag  = q.err;

    always_comb begin
        d        = q;
        tx_valid = 1'b0;
        tx_eop   = 1'b0;
        tx_data  = 8'h00;
        reg_we   = 1'b0;
        push     = 1'b0;
        pop      = 1'b0;

        rx_ready  = (q.st == ST_CMD) || (q.st == ST_WDATA) ||
                    (q.st == ST_PWRITE) || (q.st == ST_RSKIP);
        rx_fire   = rx_valid && rx_ready;
        port_more = (q.addr == LCD_LOOP_PORT) && !empty &&
                    ((limit == 8'h00) || (q.sent < limit));

        case (q.st)
            ST_CMD: begin
                if (rx_fire && !rx_eop) begin
                    d.addr   = rx_data[6:0];
                    d.nbytes = 2'd0;
                    d.sent   = 8'h00;
                    if (rx_data[7])                          d.st = ST_RSKIP;
                    else if (rx_data[6:0] >= LCD_PORT_BASE)  d.st = ST_PWRITE;
                    else                                     d.st = ST_WDATA;
                end
            end
            ST_WDATA: begin
                if (rx_fire) begin
                    if (rx_eop) begin
                        if (q.nbytes == 2'd1) reg_we = 1'b1;
                        else                  d.err  = 1'b1;
                        d.st = ST_CMD;
                    end else begin
                        if (q.nbytes == 2'd0) d.wval   = rx_data;
                        if (q.nbytes != 2'd2) d.nbytes = q.nbytes + 2'd1;
                    end
                end
            end
            ST_PWRITE: begin
                if (rx_fire) begin
                    if (rx_eop) d.st = ST_CMD;
                    else        push = (q.addr == LCD_LOOP_PORT) && !full;
                end
            end
            ST_RSKIP: begin
                if (rx_fire && rx_eop) d.st = ST_RADDR;
            end
            ST_RADDR: begin
                tx_valid = 1'b1;
                tx_data  = {1'b0, q.addr};
                if (tx_ready) d.st = (q.addr >= LCD_PORT_BASE) ? ST_RPORT : ST_RREG;
            end
            ST_RREG: begin
                tx_valid = 1'b1;
                tx_data  = reg_rdata;
                if (tx_ready) d.st = ST_REOP;
            end
            ST_RPORT: begin
                if (port_more) begin
                    tx_valid = 1'b1;
                    tx_data  = head;
                    if (tx_ready) begin
                        pop    = 1'b1;
                        d.sent = q.sent + 8'd1;
                    end
                end else begin
                    d.st = ST_REOP;
                end
            end
            ST_REOP: begin
                tx_valid = 1'b1;
                tx_eop   = 1'b1;
                if (tx_ready) d.st = ST_CMD;
            end
            default: d.st = ST_CMD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_CMD, default: '0};
        else        q <= d;
    end

endmodule

// File: rtl/lnk_cmd_decoder.sv
module lnk_cmd_decoder #(
    parameter int NREGS      = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic       rx_eop,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       tx_valid,
    output logic       tx_eop,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    output logic       err_flag
);
    logic       reg_we;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [7:0] limit;
    logic       push;
    logic       pop;
    logic       full;
    logic       empty;
    logic [7:0] head;

    lcd_parser u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_eop    (rx_eop),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .tx_valid  (tx_valid),
        .tx_eop    (tx_eop),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .limit     (limit),
        .push      (push),
        .full      (full),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .err_flag  (err_flag)
    );

    lcd_regfile #(.NREGS(NREGS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .limit (limit)
    );

    lcd_fifo #(.DEPTH(FIFO_DEPTH)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (rx_data),
        .pop       (pop),
        .head      (head),
        .full      (full),
        .empty     (empty)
    );

endmodule

// File: rtl/lcd_checker.sv
module lcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_eop,
    input logic       rx_ready,
    input logic       tx_valid,
    input logic       tx_eop,
    input logic [7:0] tx_data,
    input logic       tx_ready,
    input logic       err_flag,
    input logic       reg_we,
    input logic       push,
    input logic       pop,
    input logic       full,
    input logic       empty
);
    p_eop_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eop |-> tx_valid);

    p_no_accept_in_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);

    p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_eop)));

    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_commit_on_eop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (rx_valid && rx_eop && rx_ready));

    p_push_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    p_pop_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (!empty && tx_valid && tx_ready && !tx_eop));

endmodule

bind lnk_cmd_decoder lcd_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_eop   (rx_eop),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_eop   (tx_eop),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .err_flag (err_flag),
    .reg_we   (reg_we),
    .push     (push),
    .pop      (pop),
    .full     (full),
    .empty    (empty)
);

// File: tb/tb_lnk_cmd_decoder.sv
module tb_lnk_cmd_decoder;
    localparam int NREGS = 8;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic       rx_eop = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_ready;
    logic       tx_valid;
    logic       tx_eop;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b1;
    logic       err_flag;

    int total = 0;
    int bad = 0;
    bit stall = 1'b0;
    int cyc = 0;

    logic [8:0] expq [$];
    string      expr [$];
    logic [7:0] mreg [128];
    logic [7:0] mfifo [$];

    always #4 clk = ~clk;

    lnk_cmd_decoder #(.NREGS(NREGS), .FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_eop(rx_eop), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_eop(tx_eop), .tx_data(tx_data), .tx_ready(tx_ready),
        .err_flag(err_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: throttles tx_ready, checks hold rule, pops scoreboard.
    bit         hold_chk = 1'b0;
    logic [7:0] held_d;
    logic       held_e;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (hold_chk)
                chk(tx_valid && tx_data == held_d && tx_eop == held_e, "R8 hold",
                    {tx_valid, tx_eop, tx_data}, {1'b1, held_e, held_d});
            tx_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            hold_chk = rst_n && tx_valid && !tx_ready;
            held_d = tx_data;
            held_e = tx_eop;
            if (rst_n && tx_valid && tx_ready) begin
                chk(!rx_ready, "R8 rx_ready low in reply", rx_ready, 0);
                if (expq.size() == 0) begin
                    chk(1'b0, "R4 unexpected reply item", {tx_eop, tx_data}, 0);
                end else begin
                    logic [8:0] e;
                    string r;
                    e = expq.pop_front();
                    r = expr.pop_front();
                    chk({tx_eop, tx_data} == e, r, {tx_eop, tx_data}, e);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic put(input logic e, input logic [7:0] d);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1;
        rx_eop   = e;
        rx_data  = d;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_eop   = 1'b0;
    endtask

    task automatic expect_item(input logic e, input logic [7:0] d, input string r);
        expq.push_back({e, d});
        expr.push_back(r);
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] v);
        put(1'b0, {1'b0, a});
        put(1'b0, v);
        put(1'b1, 8'h00);
        if (a < NREGS) mreg[a] = v;
    endtask

    task automatic rd_common(input logic [6:0] a, input int extra);
        put(1'b0, {1'b1, a});
        for (int k = 0; k < extra; k++) put(1'b0, 8'h99);
        put(1'b1, 8'h00);
        chk(!rx_ready && tx_valid, "R8 backpressure after read", {rx_ready, tx_valid}, 1);
        drain();
    endtask

    task automatic rd_reg(input logic [6:0] a, input int extra, input string r);
        expect_item(1'b0, {1'b0, a}, r);
        expect_item(1'b0, (a < NREGS) ? mreg[a] : 8'h00, r);
        expect_item(1'b1, 8'h00, r);
        rd_common(a, extra);
    endtask

    task automatic wr_port(input logic [6:0] a, input int n, input logic [7:0] first);
        put(1'b0, {1'b0, a});
        for (int k = 0; k < n; k++) begin
            put(1'b0, first + 8'(k));
            if (a == 7'h60 && mfifo.size() < DEPTH) mfifo.push_back(first + 8'(k));
        end
        put(1'b1, 8'h00);
    endtask

    task automatic rd_port(input logic [6:0] a, input string r);
        int n;
        expect_item(1'b0, {1'b0, a}, r);
        if (a == 7'h60) begin
            n = mfifo.size();
            if (mreg[NREGS-1] != 0 && n > int'(mreg[NREGS-1])) n = int'(mreg[NREGS-1]);
            for (int k = 0; k < n; k++) expect_item(1'b0, mfifo.pop_front(), r);
        end
        expect_item(1'b1, 8'h00, r);
        rd_common(a, 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mreg[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(!tx_valid, "R9 tx_valid", tx_valid, 0);
        chk(rx_ready, "R9 rx_ready", rx_ready, 1);
        chk(!err_flag, "R9 err_flag", err_flag, 0);
        rd_reg(7'h03, 0, "R9 register reset value");
        rd_port(7'h60, "R9 fifo empty after reset");

        // R2 writes and readback
        wr_reg(7'h02, 8'hA5);
        wr_reg(7'h00, 8'h3C);
        wr_reg(7'h06, 8'hFF);
        rd_reg(7'h02, 0, "R2 readback reg2");
        rd_reg(7'h00, 0, "R2 readback reg0");
        rd_reg(7'h06, 0, "R2 readback reg6");
        chk(!err_flag, "R3 no error on good writes", err_flag, 0);

        // R3 malformed writes
        put(1'b0, 8'h02);
        put(1'b1, 8'h00);
        chk(err_flag, "R3 zero-byte write flags", err_flag, 1);
        rd_reg(7'h02, 0, "R3 zero-byte write ignored");
        put(1'b0, 8'h02);
        put(1'b0, 8'h11);
        put(1'b0, 8'h22);
        put(1'b1, 8'h00);
        rd_reg(7'h02, 0, "R3 two-byte write ignored");
        chk(err_flag, "R3 flag sticky", err_flag, 1);

        // R5 unmapped
        wr_reg(7'h20, 8'h77);
        rd_reg(7'h20, 0, "R5 unmapped reads zero");
        rd_reg(7'h5F, 0, "R5 top of register range");
        wr_reg(7'h08, 8'h44);
        rd_reg(7'h08, 0, "R5 first unmapped");

        // R4 extra bytes in read; R1 empty packet
        rd_reg(7'h02, 2, "R4 read ignores extra bytes");
        put(1'b1, 8'h00);
        chk(rx_ready && !tx_valid, "R1 empty packet ignored", {rx_ready, tx_valid}, 2);
        rd_reg(7'h00, 0, "R1 command after empty packet");

        // R6 / R7 port behaviour
        wr_port(7'h60, 3, 8'h10);
        rd_port(7'h60, "R7 port read drains");
        wr_port(7'h60, 6, 8'h01);
        rd_port(7'h60, "R6 overflow drops extra bytes");
        wr_port(7'h61, 1, 8'h55);
        rd_port(7'h61, "R7 other port address only");
        rd_port(7'h60, "R6 other port write discarded");

        // R7 length limit
        wr_reg(7'h07, 8'h02);
        wr_port(7'h60, 3, 8'hA0);
        rd_port(7'h60, "R7 limited read");
        rd_port(7'h60, "R7 remainder kept");
        wr_reg(7'h07, 8'h00);
        rd_reg(7'h07, 0, "R7 limit register readback");

        // R8 throttled output
        stall = 1'b1;
        rd_reg(7'h06, 0, "R8 stalled register reply");
        wr_port(7'h60, 4, 8'hC0);
        rd_port(7'h60, "R8 stalled port reply");
        stall = 1'b0;
        drain();

        chk(expq.size() == 0, "R4 all replies seen", expq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule